// File: doc/BRIEF.md
# Code-Indexed Linearity Correction Lookup

This block supplies the digital correction values that accompany the main code of a precision current-steering DAC. Each time the DAC register is loaded, the block registers the new 14-bit code. In the same cycle it registers a 12-bit linearity correction word. The correction word is picked by the five upper bits of the code. Because one stored word covers each whole combination of those upper bits, the correction can cancel errors that come from interaction between bits, which a bit-by-bit trim cannot do. Upper-bit value zero needs no stored word and always yields a correction of zero. The other 31 values each own one table word.

The block also holds two values that do not depend on the code. One is a 6-bit gain trim word. The other is a feedback-select bit, which picks single-unit feedback for unipolar use or double-unit feedback for bipolar use. The two uses need different table contents. All stored values are loaded through a programming port, which reuses the data inputs while the active-low program-mode input is held low. In normal operation that input stays high and every program write is ignored. Storage is modelled as plain registers.

Top module: `lincorr_lookup`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_code`, `corr_code`, `gain_code` and `fb_double` are all zero after that edge.
- R2: A cycle with `dac_load` high makes `dac_code` equal to the `dac_next` value of that cycle, starting at the next clock edge.
- R3: When the loaded code has bits [13:9] equal to zero, `corr_code` becomes zero at the same edge as `dac_code`.
- R4: When the loaded code has bits [13:9] equal to k, with k from 1 to 31, `corr_code` becomes table word k at the same edge as `dac_code`.
- R5: Bits [8:0] of the loaded code have no effect on `corr_code`.
- R6: In a cycle with `dac_load` low, `dac_code` and `corr_code` keep their values, even if `dac_next` changes.
- R7: A cycle with `prog_n` low, `prog_we` high and `prog_addr` = k (1 to 31) stores `prog_data[11:0]` as table word k.
- R8: A cycle with `prog_n` low, `prog_we` high and `prog_addr` = 0 sets `gain_code` to `prog_data[5:0]` and `fb_double` to `prog_data[6]`. Both outputs show the new values from the next edge on.
- R9: While `prog_n` is high, `prog_we` changes no table word, no `gain_code` and no `fb_double`.
- R10: Rewriting a table word does not change `corr_code` until the next `dac_load`, so the code and its correction stay paired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dac_load | input | 1 | Load strobe of the DAC register |
| dac_next | input | 14 | Code to load into the DAC register |
| prog_n | input | 1 | Program mode, active low; held high in normal use |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | 5 | 0 selects gain/feedback word, 1..31 select a table word |
| prog_data | input | 14 | Program data, shared with the data inputs |
| dac_code | output | 14 | Registered DAC code |
| corr_code | output | 12 | Linearity correction aligned with `dac_code` |
| gain_code | output | 6 | Gain trim word |
| fb_double | output | 1 | 1 = double-unit feedback (bipolar), 0 = single unit |

## Verification
The bench loads codes at every upper-bit value from 0 to 31. A design that indexed the table off by one, or that read a stored word for index zero, would show the wrong correction at one end. It also loads pairs of codes that differ only in the lower nine bits; a design that took its index from the wrong bits would give different corrections for such a pair. Program writes made with program mode inactive must leave the table, the gain word and the feedback bit unchanged. A table word rewritten while its code is live must not show until the next load; a design with a combinational correction path would change `corr_code` early and break the pairing with `dac_code`.

// File: rtl/lincorr_pkg.sv
package lincorr_pkg;

    // Feedback resistance choice driven by the stored mode bit
    typedef enum logic [0:0] {
        FB_SINGLE = 1'b0,
        FB_DOUBLE = 1'b1
    } fb_sel_e;

    // Target of a programming cycle
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_TRIM = 2'd1,
        WR_WORD = 2'd2
    } wr_kind_e;

    // Decode one programming cycle: active-low mode, strobe, address-zero flag
    function automatic wr_kind_e wr_decode(input logic mode_n,
                                           input logic strobe,
                                           input logic addr_zero);
        wr_kind_e k;
        if (mode_n || !strobe) begin
            k = WR_NONE;
        end else if (addr_zero) begin
            k = WR_TRIM;
        end else begin
            k = WR_WORD;
        end
        return k;
    endfunction

endpackage

// File: rtl/lincorr_table.sv
module lincorr_table #(
    parameter int SEL_W  = 5,
    parameter int CORR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CORR_W-1:0] wr_word,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CORR_W-1:0] rd_word
);
    localparam int SLOTS   = 1 << SEL_W;
    localparam int ENTRIES = SLOTS - 1;

    // Slot 0 is a constant zero; slots 1..ENTRIES are storage
    logic [CORR_W-1:0] words [SLOTS];

    assign words[0] = '0;

    for (genvar i = 1; i <= ENTRIES; i++) begin : g_entry
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
        logic [CORR_W-1:0] ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_en && (wr_sel == MY_SEL)) begin
                ent_q <= wr_word;
            end
        end

        assign words[i] = ent_q;

        // R7
        word_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_sel == MY_SEL)) |=> (ent_q == $past(wr_word)));
    end

    assign rd_word = words[rd_sel];

endmodule

// File: rtl/lincorr_trim.sv
module lincorr_trim
    import lincorr_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [GAIN_W-1:0] gain_in,
    input  fb_sel_e           fb_in,
    output logic [GAIN_W-1:0] gain_q,
    output fb_sel_e           fb_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= '0;
            fb_q   <= FB_SINGLE;
        end else if (wr_en) begin
            gain_q <= gain_in;
            fb_q   <= fb_in;
        end
    end

    // R8
    trim_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (gain_q == $past(gain_in)) && (fb_q == $past(fb_in)));

endmodule

// File: rtl/lincorr_align.sv
module lincorr_align #(
    parameter int CODE_W = 14,
    parameter int SEL_W  = 5,
    parameter int CORR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CORR_W-1:0] corr_in,
    output logic [CODE_W-1:0] code_q,
    output logic [CORR_W-1:0] corr_q
);
    localparam int SEL_LO = CODE_W - SEL_W;

    // Code and correction share one enable so they never drift apart
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            corr_q <= '0;
        end else if (load) begin
            code_q <= code_in;
            corr_q <= corr_in;
        end
    end

    // R2
    code_follow_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (code_q == $past(code_in)));

    // R3
    zero_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (code_in[CODE_W-1:SEL_LO] == '0)) |=> (corr_q == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(code_q) && $stable(corr_q)));

endmodule

// File: rtl/lincorr_lookup.sv
module lincorr_lookup
    import lincorr_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int SEL_W  = 5,
    parameter int CORR_W = 12,
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dac_load,
    input  logic [CODE_W-1:0] dac_next,
    input  logic              prog_n,
    input  logic              prog_we,
    input  logic [SEL_W-1:0]  prog_addr,
    input  logic [CODE_W-1:0] prog_data,
    output logic [CODE_W-1:0] dac_code,
    output logic [CORR_W-1:0] corr_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic              fb_double
);
    localparam int SEL_LO = CODE_W - SEL_W;

    wr_kind_e          wr_kind;
    logic [SEL_W-1:0]  look_sel;
    logic [CORR_W-1:0] look_word;
    fb_sel_e           fb_in;
    fb_sel_e           fb_q;

    assign wr_kind  = wr_decode(prog_n, prog_we, prog_addr == '0);
    assign look_sel = dac_next[CODE_W-1:SEL_LO];
    assign fb_in    = fb_sel_e'(prog_data[GAIN_W]);

    lincorr_table #(
        .SEL_W  (SEL_W),
        .CORR_W (CORR_W)
    ) table_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_kind == WR_WORD),
        .wr_sel  (prog_addr),
        .wr_word (prog_data[CORR_W-1:0]),
        .rd_sel  (look_sel),
        .rd_word (look_word)
    );

    lincorr_trim #(
        .GAIN_W (GAIN_W)
    ) trim_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_kind == WR_TRIM),
        .gain_in (prog_data[GAIN_W-1:0]),
        .fb_in   (fb_in),
        .gain_q  (gain_code),
        .fb_q    (fb_q)
    );

    lincorr_align #(
        .CODE_W (CODE_W),
        .SEL_W  (SEL_W),
        .CORR_W (CORR_W)
    ) align_i (
        .clk     (clk),
        .rst     (rst),
        .load    (dac_load),
        .code_in (dac_next),
        .corr_in (look_word),
        .code_q  (dac_code),
        .corr_q  (corr_code)
    );

    assign fb_double = (fb_q == FB_DOUBLE);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && (corr_code == '0) && (gain_code == '0) && !fb_double);

    // R9
    trim_lock_chk: assert property (@(posedge clk) disable iff (rst)
        prog_n |=> ($stable(gain_code) && $stable(fb_double)));

endmodule

// File: tb/lincorr_lookup_tb_top.sv
module lincorr_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dac_load = 1'b0;
    logic [13:0] dac_next = '0;
    logic        prog_n = 1'b1;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_addr = '0;
    logic [13:0] prog_data = '0;
    logic [13:0] dac_code;
    logic [11:0] corr_code;
    logic [5:0]  gain_code;
    logic        fb_double;

    int checks = 0;
    int fails  = 0;
    logic [11:0] model [32];

    always #10 clk = ~clk;

    lincorr_lookup dut_i (
        .clk(clk), .rst(rst), .dac_load(dac_load), .dac_next(dac_next),
        .prog_n(prog_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .dac_code(dac_code), .corr_code(corr_code),
        .gain_code(gain_code), .fb_double(fb_double)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pattern(input int k, input int salt);
        return 12'((k * 157 + salt) & 12'hfff);
    endfunction

    task automatic load_code(input logic [13:0] c);
        @(negedge clk);
        dac_load = 1'b1;
        dac_next = c;
        @(negedge clk);
        dac_load = 1'b0;
    endtask

    task automatic prog_write(input logic mode_n, input logic [4:0] a, input logic [13:0] d);
        @(negedge clk);
        prog_n    = mode_n;
        prog_we   = 1'b1;
        prog_addr = a;
        prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
        prog_n  = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 dac_code", dac_code, 0);
        check("R1 corr_code", corr_code, 0);
        check("R1 gain_code", gain_code, 0);
        check("R1 fb_double", fb_double, 0);
    endtask

    task automatic t_fill_and_scan();
        model[0] = '0;
        for (int k = 1; k < 32; k++) begin
            model[k] = pattern(k, 58);
            prog_write(1'b0, 5'(k), {2'b11, model[k]});
        end
        for (int k = 0; k < 32; k++) begin
            logic [13:0] c;
            c = {5'(k), 9'(k * 13 + 5)};
            load_code(c);
            check("R2 code follows", dac_code, c);
            if (k == 0) check("R3 zero index", corr_code, 0);
            else        check("R4 table word", corr_code, model[k]);
        end
    endtask

    task automatic t_low_bits();
        load_code({5'd17, 9'h000});
        check("R5 low bits zero", corr_code, model[17]);
        load_code({5'd17, 9'h1ff});
        check("R5 low bits ones", corr_code, model[17]);
        load_code({5'd0, 9'h1ff});
        check("R3 zero index, low ones", corr_code, 0);
        load_code({5'd31, 9'h0aa});
        check("R4 top word", corr_code, model[31]);
        check("R2 top word code", dac_code, {5'd31, 9'h0aa});
    endtask

    task automatic t_hold();
        load_code({5'd9, 9'h033});
        @(negedge clk);
        dac_next = {5'd20, 9'h111};
        repeat (3) @(negedge clk);
        check("R6 code held", dac_code, {5'd9, 9'h033});
        check("R6 corr held", corr_code, model[9]);
    endtask

    task automatic t_trim();
        prog_write(1'b0, 5'd0, 14'h0055);
        check("R8 gain", gain_code, 6'h15);
        check("R8 fb double", fb_double, 1);
        prog_write(1'b0, 5'd0, 14'h002a);
        check("R8 gain second", gain_code, 6'h2a);
        check("R8 fb single", fb_double, 0);
    endtask

    task automatic t_locked();
        prog_write(1'b1, 5'd0, 14'h007f);
        check("R9 gain locked", gain_code, 6'h2a);
        check("R9 fb locked", fb_double, 0);
        prog_write(1'b1, 5'd12, 14'h0abc);
        load_code({5'd12, 9'h001});
        check("R9 word locked", corr_code, model[12]);
    endtask

    task automatic t_defer();
        load_code({5'd3, 9'h044});
        model[3] = pattern(3, 901);
        prog_write(1'b0, 5'd3, {2'b00, model[3]});
        @(negedge clk);
        check("R10 no early change", corr_code, pattern(3, 58));
        load_code({5'd3, 9'h044});
        check("R10 new word after load", corr_code, model[3]);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_and_scan();
        t_low_bits();
        t_hold();
        t_trim();
        t_locked();
        t_defer();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule